// File: doc/BRIEF.md
# Pointer-Redirect Survivor Memory for a Viterbi Decoder

This block stores the survivor paths of a Viterbi decoder. Each trellis state owns one physical row of survivor bits. When a state inherits the path of a predecessor, the row is not moved. Instead, a per-state pointer is changed to name the predecessor's physical row. Each row is a circular buffer of depth `D`. On every trellis step, the newest decision bit is written into the current column of every row, and a shared column index then advances modulo `D`.

An add-compare-select stage outside this block presents one decision bit per state together with a step strobe. The two successor states of a butterfly can both pick the same predecessor. In that case the lower successor takes the shared row. The row of the predecessor that nobody picked is then free, so it is given to the upper successor and loaded with a copy of the shared row in the same cycle. After `D` steps have filled the buffers, each further step emits the oldest bit of the survivor of state 0, marked by a one-cycle valid strobe.

The constraint length `K` and the depth `D` are parameters. The defaults are `K = 9`, which gives 256 states, and `D = 32`.

Top module: `ptr_survivor_mem`

## Requirements
- R1: While `rst` is high at a rising edge, every state pointer is set to its own row (state s names row s), the column index and fill count are cleared, and `out_valid` is low in the following cycle.
- R2: After reset, the first `D-1` steps produce `out_valid` low; the `D`-th step and every later step produce `out_valid` high.
- R3: `out_valid` is a registered single-cycle strobe. It is high only in the cycle that follows a rising edge at which `step_valid` was high, and low in any cycle that follows an edge without a step.
- R4: On a step, state s takes the survivor of predecessor `s>>1` when `step_dec[s]` is 0, and of `(s>>1) | 2^(K-2)` when it is 1. The bit appended to its survivor is bit K-2 (the MSB) of s.
- R5: When `out_valid` is high, `out_bit` equals the bit appended `D-1` steps before the current step on the survivor of state 0. This is the oldest bit of a `D`-deep copy-based register exchange with the same rule.
- R6: When both successors of a butterfly (states 2j and 2j+1) pick the same predecessor, both survivors continue that predecessor's path. The lower successor keeps the row, and the upper one receives the unclaimed row holding a copy of it.
- R7: A cycle with `step_valid` low leaves all survivor state unchanged and ignores `step_dec`. Later outputs match a stream in which that cycle did not occur.
- R8: Asserting `rst` in the middle of a stream restarts the fill count, so the next `D-1` steps again produce no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Advances the trellis by one step at this edge |
| step_dec | input | 2^(K-1) | Decision bit for each state; bit s belongs to state s |
| out_valid | output | 1 | Strobe: `out_bit` holds a decoded bit |
| out_bit | output | 1 | Oldest survivor bit of state 0 |

## Verification
Every step result is registered. The decoded bit and its strobe therefore appear in the cycle right after the rising edge that accepted the step. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is half a period after that rising edge. Idle cycles and the cycle after a reset are sampled at the same point, with `out_valid` expected low. `out_bit` is compared only when the reference copy-based exchange says a bit is due. That reference counts steps since reset, so the first expected strobe falls on the `D`-th step.

// File: rtl/svm_pkg.sv
package svm_pkg;

  // Row copy that a butterfly needs on a step.
  // A2B: row of the low predecessor is copied into the row of the high one.
  // B2A: the reverse.
  typedef enum logic [1:0] {
    CP_NONE = 2'd0,
    CP_A2B  = 2'd1,
    CP_B2A  = 2'd2
  } copy_e;

endpackage

// File: rtl/svm_pair_alloc.sv
// Row allocation for one butterfly.
// Predecessors: A = j (low), B = j + H (high). Successors: 2j (lo), 2j+1 (hi).
// If both successors claim the same predecessor, the other predecessor's row
// has no pointer left on it, so it is free and is handed to the hi successor.
module svm_pair_alloc
  import svm_pkg::*;
(
  input  logic  dec_lo,
  input  logic  dec_hi,
  output logic  lo_takes_b,
  output logic  hi_takes_b,
  output copy_e copy
);

  always_comb begin
    // The lo successor always gets the row it asked for.
    lo_takes_b = dec_lo;
    // The hi successor gets whichever row the lo one left behind.
    hi_takes_b = ~dec_lo;
    if (!dec_lo && !dec_hi)     copy = CP_A2B;
    else if (dec_lo && dec_hi)  copy = CP_B2A;
    else                        copy = CP_NONE;
  end

endmodule

// File: rtl/svm_ptr_table.sv
// State-to-row pointer table with redirect-on-step.
module svm_ptr_table
  import svm_pkg::*;
#(
  parameter  int K  = 9,
  localparam int NS = 1 << (K - 1),
  localparam int H  = NS / 2,
  localparam int RW = K - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [NS-1:0] dec,
  output logic [RW-1:0] ptr_q  [NS],
  output copy_e         copy_o [H]
);

  logic [RW-1:0] ptr_d [NS];

  for (genvar j = 0; j < H; j++) begin : g_pair
    logic lo_b, hi_b;

    svm_pair_alloc u_alloc (
      .dec_lo     (dec[2*j]),
      .dec_hi     (dec[2*j+1]),
      .lo_takes_b (lo_b),
      .hi_takes_b (hi_b),
      .copy       (copy_o[j])
    );

    assign ptr_d[2*j]   = lo_b ? ptr_q[j+H] : ptr_q[j];
    assign ptr_d[2*j+1] = hi_b ? ptr_q[j+H] : ptr_q[j];

    // R6: the two successors of a butterfly never share a physical row.
    a_r6_pair_distinct: assert property (
      @(posedge clk) disable iff (rst)
      ptr_q[2*j] != ptr_q[2*j+1]
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) ptr_q[s] <= RW'(s);
    end else if (step) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/svm_col_ctrl.sv
// Shared circular column index and fill tracking.
module svm_col_ctrl #(
  parameter  int D  = 32,
  localparam int CW = $clog2(D),
  localparam int FW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] col_q,
  output logic [CW-1:0] col_nx,
  output logic          primed
);

  logic [FW-1:0] fill_q;

  assign col_nx = (col_q == CW'(D - 1)) ? '0 : col_q + 1'b1;
  assign primed = (fill_q == FW'(D - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      fill_q <= '0;
    end else if (step) begin
      col_q <= col_nx;
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  // R5: the column index stays inside the row.
  a_r5_col_range: assert property (
    @(posedge clk) disable iff (rst)
    int'(col_q) < D
  );

  // R5: the last column wraps back to column zero on a step.
  a_r5_col_wrap: assert property (
    @(posedge clk) disable iff (rst)
    (step && col_q == CW'(D - 1)) |=> (col_q == '0)
  );

  // R7: without a step, the column index holds its value.
  a_r7_col_hold: assert property (
    @(posedge clk) disable iff (rst)
    !step |=> $stable(col_q)
  );

endmodule

// File: rtl/svm_row_bank.sv
// Physical survivor rows. Each row is a circular buffer of D bits.
// One read port returns a single bit.
module svm_row_bank
  import svm_pkg::*;
#(
  parameter  int K  = 9,
  parameter  int D  = 32,
  localparam int NS = 1 << (K - 1),
  localparam int H  = NS / 2,
  localparam int RW = K - 1,
  localparam int CW = $clog2(D)
) (
  input  logic          clk,
  input  logic          step,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] ptr     [NS],
  input  copy_e         copy    [H],
  input  logic          app_bit [H],
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic          rd_bit
);

  logic [D-1:0] rows   [NS];
  logic [D-1:0] rows_d [NS];

  // Each butterfly writes exactly its own two rows.
  // The pointers form a permutation, so every row is written once per step.
  always_comb begin
    rows_d = rows;
    for (int j = 0; j < H; j++) begin
      logic [RW-1:0] ra_idx, rb_idx;
      logic [D-1:0]  ra, rb;
      ra_idx = ptr[j];
      rb_idx = ptr[j+H];
      ra = (copy[j] == CP_B2A) ? rows[rb_idx] : rows[ra_idx];
      rb = (copy[j] == CP_A2B) ? rows[ra_idx] : rows[rb_idx];
      ra[col] = app_bit[j];
      rb[col] = app_bit[j];
      rows_d[ra_idx] = ra;
      rows_d[rb_idx] = rb;
    end
  end

  always_ff @(posedge clk) begin
    if (step) rows <= rows_d;
  end

  assign rd_bit = rows[rd_row][rd_col];

endmodule

// File: rtl/ptr_survivor_mem.sv
// Survivor memory: per-state pointers redirect to physical rows instead of
// copying rows between states.
module ptr_survivor_mem
  import svm_pkg::*;
#(
  parameter  int K  = 9,
  parameter  int D  = 32,
  localparam int NS = 1 << (K - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_valid,
  input  logic [NS-1:0] step_dec,
  output logic          out_valid,
  output logic          out_bit
);

  localparam int H  = NS / 2;
  localparam int RW = K - 1;
  localparam int CW = $clog2(D);

  logic [RW-1:0] ptr     [NS];
  copy_e         copy    [H];
  logic          app_bit [H];
  logic [CW-1:0] col_q, col_nx;
  logic          primed;
  logic [RW-1:0] rd_row;
  logic          rd_bit;

  // Successors 2j and 2j+1 share bit K-2, which is bit K-3 of j.
  for (genvar j = 0; j < H; j++) begin : g_bit
    assign app_bit[j] = ((j >> (K - 3)) & 1) != 0;
  end

  svm_ptr_table #(.K(K)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .step   (step_valid),
    .dec    (step_dec),
    .ptr_q  (ptr),
    .copy_o (copy)
  );

  svm_col_ctrl #(.D(D)) u_col (
    .clk    (clk),
    .rst    (rst),
    .step   (step_valid),
    .col_q  (col_q),
    .col_nx (col_nx),
    .primed (primed)
  );

  // State 0 inherits the row of predecessor 0 or H. Its oldest bit after the
  // step sits in column col_nx, which this step does not overwrite.
  assign rd_row = step_dec[0] ? ptr[H] : ptr[0];

  svm_row_bank #(.K(K), .D(D)) u_rows (
    .clk     (clk),
    .step    (step_valid),
    .col     (col_q),
    .ptr     (ptr),
    .copy    (copy),
    .app_bit (app_bit),
    .rd_row  (rd_row),
    .rd_col  (col_nx),
    .rd_bit  (rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= step_valid && primed;
      if (step_valid) out_bit <= rd_bit;
    end
  end

  // R3: a strobe is only ever produced by a step at the previous edge.
  a_r3_valid_after_step: assert property (
    @(posedge clk) disable iff (rst)
    out_valid |-> $past(step_valid)
  );

  // R3: an edge without a step is always followed by a low strobe.
  a_r3_idle_no_valid: assert property (
    @(posedge clk) disable iff (rst)
    !step_valid |=> !out_valid
  );

endmodule

// File: tb/tb_ptr_survivor_mem.sv
module tb_ptr_survivor_mem;

  localparam int K          = 4;
  localparam int D          = 6;
  localparam int NS         = 1 << (K - 1);
  localparam int H          = NS / 2;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_valid = 1'b0;
  logic [NS-1:0] step_dec = '0;
  logic          out_valid, out_bit;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Copy-based register-exchange reference.
  logic [D-1:0] m [NS];
  int           t;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_survivor_mem #(.K(K), .D(D)) dut (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .step_dec   (step_dec),
    .out_valid  (out_valid),
    .out_bit    (out_bit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++) m[s] = '0;
    t = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic do_step(input logic [NS-1:0] d, input string tag);
    logic [D-1:0] nw [NS];
    logic         exp_v, exp_b;
    for (int s = 0; s < NS; s++) begin
      int p;
      p = (s >> 1) | (d[s] ? H : 0);
      nw[s] = {m[p][D-2:0], 1'((s >> (K - 2)) & 1)};
    end
    for (int s = 0; s < NS; s++) m[s] = nw[s];
    t++;
    exp_v = (t >= D);
    exp_b = nw[0][D-1];
    step_valid = 1'b1;
    step_dec   = d;
    @(posedge clk);
    @(negedge clk);
    step_valid = 1'b0;
    check({tag, " valid"}, out_valid, exp_v);
    if (exp_v) check({tag, " bit"}, out_bit, exp_b);
  endtask

  task automatic do_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step_dec = NS'($urandom());
      @(negedge clk);
      check({tag, " idle valid"}, out_valid, 1'b0);
    end
  endtask

  // R1: reset state
  task automatic t_reset_state();
    do_reset();
    check("R1 after reset", out_valid, 1'b0);
    @(negedge clk);
    check("R1 held low", out_valid, 1'b0);
  endtask

  // R2: fill latency of D steps
  task automatic t_fill();
    do_reset();
    for (int i = 0; i < D; i++) do_step(NS'($urandom()), "R2");
  endtask

  // R3: single-cycle strobe
  task automatic t_strobe();
    do_step(NS'($urandom()), "R3");
    do_idle(2, "R3");
    do_step(NS'($urandom()), "R3");
  endtask

  // R4: structured decision pattern
  task automatic t_trellis();
    logic [NS-1:0] pat;
    do_reset();
    pat = NS'(8'b1011_0010);
    for (int i = 0; i < 30; i++) begin
      do_step(pat, "R4");
      pat = {pat[NS-2:0], pat[NS-1] ^ pat[0]};
    end
  endtask

  // R5: random decision stream
  task automatic t_random();
    do_reset();
    for (int i = 0; i < 150; i++) do_step(NS'($urandom()), "R5");
  endtask

  // R6: both successors of each butterfly pick the same predecessor
  task automatic t_conflict();
    do_reset();
    for (int i = 0; i < 15; i++) do_step('0, "R6");
    for (int i = 0; i < 15; i++) do_step('1, "R6");
    for (int i = 0; i < 40; i++) begin
      logic [H-1:0]  r;
      logic [NS-1:0] d;
      r = H'($urandom());
      for (int j = 0; j < H; j++) begin
        d[2*j]   = r[j];
        d[2*j+1] = r[j];
      end
      do_step(d, "R6");
    end
  endtask

  // R7: decisions ignored without a step
  task automatic t_idle();
    do_reset();
    for (int i = 0; i < 10; i++) do_step(NS'($urandom()), "R7");
    do_idle(5, "R7");
    for (int i = 0; i < 20; i++) begin
      do_step(NS'($urandom()), "R7");
      if (i % 3 == 0) do_idle(1, "R7");
    end
  endtask

  // R8: reset in the middle of a stream
  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) do_step(NS'($urandom()), "R8 pre");
    do_reset();
    for (int i = 0; i < D + 3; i++) do_step(NS'($urandom()), "R8");
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    model_clear();
    t_reset_state();
    t_fill();
    t_strobe();
    t_trellis();
    t_random();
    t_conflict();
    t_idle();
    t_reset_mid();
    done = 1;
    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

endmodule